// File: doc/BRIEF.md
# Minifloat to fixed-point decoder

The block takes one byte in an 8-bit floating-point format and turns it into a class code, a sign and an exact unsigned fixed-point magnitude. The byte holds a 1-bit sign, a 4-bit exponent biased by 7 and a 3-bit fraction. A byte arrives with a valid strobe. One clock later the registered result appears, together with a matching valid.

The magnitude has 8 integer bits and 9 fraction bits. Every finite value in the format fits this width exactly, from the smallest denormal (2^-9) up to the largest normal (240), so no rounding takes place. Infinity and NaN are reported through the class code, and their magnitude is zero.

Top module: `mfloat_decode`

## Requirements
- R1: After reset, out_valid is 0 and class_o, sign_o and mag_o are all 0.
- R2: out_valid is in_valid delayed by one clock. The other outputs load only in a cycle where in_valid is 1 and otherwise keep their value.
- R3: Input bits are sign = bit 7, exponent = bits 6:3, fraction = bits 2:0. sign_o equals bit 7 of the accepted byte for every class, including zero, infinity and NaN.
- R4: For exponent 1 to 14, mag_o equals (8 + fraction) × 2^(exponent − 7) / 8, expressed in units of 2^-9. For example, 0x42 gives 2.5 (0x0500) and 0x4B gives 5.5 (0x0B00).
- R5: For exponent 0, mag_o equals fraction × 2^-9. So 0x01 gives 1 LSB, and 0x07 gives 7 LSB.
- R6: Class codes are 0 = zero, 1 = denormal, 2 = normal, 3 = infinity, 4 = NaN. Bytes 0x00 and 0x80 are zero, not denormal.
- R7: For exponent 15, the class is infinity when the fraction is 0 and NaN otherwise. In both cases mag_o is 0.
- R8: The largest finite byte 0x77 gives 240.0 (0x1E000), and mag_o never exceeds that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Encoded minifloat |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| class_o | output | 3 | Class code |
| sign_o | output | 1 | Sign of the accepted byte |
| mag_o | output | 17 | Magnitude, unsigned, 8 integer and 9 fraction bits |

## Verification
All 256 encodings are applied, plus random bytes with random gaps in the strobe. A broken shift amount or a broken implicit-one selection shows up as a wrong magnitude on the very next cycle, paired with the byte that caused it. A wrong class boundary shows up in the same way: 0x00/0x80, exponent 0 against exponent 1, or exponent 15. A register that loads when the strobe is low shows up as an output that changes during an idle cycle.

// File: rtl/mfloat_decode.sv
module mfloat_decode #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 3,
  parameter int INT_W  = 8,
  parameter int FIX_W  = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+FRAC_W:0]  in_byte,
  output logic                   out_valid,
  output logic [2:0]             class_o,
  output logic                   sign_o,
  output logic [INT_W+FIX_W-1:0] mag_o
);
  localparam int MAG_W = INT_W + FIX_W;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [2:0] C_ZERO = 3'd0, C_DEN = 3'd1, C_NORM = 3'd2, C_INF = 3'd3, C_NAN = 3'd4;

  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [2:0]        cls;
  logic [MAG_W-1:0]  mag;
  logic [MAG_W-1:0]  mant;

  assign e = in_byte[EXP_W+FRAC_W-1:FRAC_W];
  assign f = in_byte[FRAC_W-1:0];
  assign mant = MAG_W'({(e != '0), f});

  always_comb begin
    if (e == EXP_MAX)   cls = (f == '0) ? C_INF : C_NAN;
    else if (e != '0)   cls = C_NORM;
    else if (f != '0)   cls = C_DEN;
    else                cls = C_ZERO;
  end

  always_comb begin
    if (e == EXP_MAX)   mag = '0;
    else if (e == '0)   mag = mant;
    else                mag = mant << (e - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      class_o   <= '0;
      sign_o    <= 1'b0;
      mag_o     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        class_o <= cls;
        sign_o  <= in_byte[EXP_W+FRAC_W];
        mag_o   <= mag;
      end
    end
  end

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(mag_o) && $stable(class_o) && $stable(sign_o)));
  a_r3_sign_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |-> sign_o == $past(in_byte[EXP_W+FRAC_W]));
  a_r6_class_legal: assert property (@(posedge clk) disable iff (!rst_n)
    class_o <= C_NAN);
  a_r7_special_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (class_o == C_INF || class_o == C_NAN) |-> mag_o == '0);
  a_r6_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (class_o == C_ZERO) |-> mag_o == '0);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    mag_o <= MAG_W'(17'h1E000));
endmodule

// File: tb/test_mfloat_decode.sv
module test_mfloat_decode;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic out_valid, sign_o;
  logic [2:0] class_o;
  logic [16:0] mag_o;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  mfloat_decode i_mfloat_decode (.clk, .rst_n, .in_valid, .in_byte,
    .out_valid, .class_o, .sign_o, .mag_o);

  function automatic logic [2:0] exp_cls(input logic [7:0] b);
    if (b[6:3] == 4'hF) return (b[2:0] == 0) ? 3'd3 : 3'd4;
    if (b[6:3] != 0) return 3'd2;
    return (b[2:0] != 0) ? 3'd1 : 3'd0;
  endfunction

  function automatic logic [16:0] exp_mag(input logic [7:0] b);
    int e = int'(b[6:3]);
    int f = int'(b[2:0]);
    longint v;
    if (e == 15) return 0;
    if (e == 0) return 17'(f);
    v = longint'(8 + f);
    for (int k = 1; k < e; k++) v = v * 2;
    return 17'(v);
  endfunction

  task automatic chk(input string rq, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
    end
  endtask

  task automatic apply(input logic [7:0] b);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(negedge clk); in_valid = 0;
    chk("R2", out_valid, 1);
    chk("R6", class_o, exp_cls(b));
    chk("R3", sign_o, b[7]);
    if (b[6:3] == 0) chk("R5", mag_o, exp_mag(b));
    else if (b[6:3] == 15) chk("R7", mag_o, 0);
    else chk("R4", mag_o, exp_mag(b));
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [16:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1", out_valid, 0); chk("R1", class_o, 0);
    chk("R1", sign_o, 0); chk("R1", mag_o, 0);
    rst_n = 1;
    apply(8'h42); chk("R4", mag_o, 17'h0500);
    apply(8'h4B); chk("R4", mag_o, 17'h0B00);
    apply(8'h01); chk("R5", mag_o, 1);
    apply(8'h77); chk("R8", mag_o, 17'h1E000);
    apply(8'h80); chk("R6", class_o, 0); chk("R3", sign_o, 1);
    apply(8'h08); chk("R6", class_o, 2); chk("R4", mag_o, 17'h0008);
    apply(8'hF8); chk("R7", class_o, 3); chk("R3", sign_o, 1);
    apply(8'h7C); chk("R7", class_o, 4);
    held = mag_o;
    @(negedge clk); in_byte = 8'h42;
    @(negedge clk);
    chk("R2", out_valid, 0); chk("R2", mag_o, held); chk("R2", class_o, 4);
    for (int b = 0; b < 256; b++) apply(8'(b));
    for (int n = 0; n < 300; n++) begin
      logic [7:0] r = 8'($urandom);
      if ($urandom % 3 == 0) @(negedge clk);
      apply(r);
      checks++;
      if (mag_o > 17'h1E000) begin errs++; $display("FAIL R8 actual=%0h expected<=1e000", mag_o); end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule